// File: doc/BRIEF.md
# Bus Cycle Break Comparator

This block watches each bus cycle the processor issues and raises a break interrupt request when the cycle fits a programmed condition. The condition has two parts. The first is a break address with a per-bit mask: a mask bit of 1 leaves that address bit out of the compare. The second is three two-bit selectors that filter on the initiator (processor or peripheral), the access kind (instruction fetch or data access) and the direction (read or write).

A matching cycle sets a pending flag. The flag is offered to the interrupt logic as a request with fixed priority 15. While the processor's interrupt mask level is 15 the flag is kept but not offered. It is offered as soon as the level drops to 14 or lower, and it stays set until the acceptance acknowledge arrives. Software programs the three condition registers through separate write enables and can read each one back.

Top module: `bus_break_unit`

## Requirements
- R1: A bus cycle's address fits the condition when it equals the break address on every bit whose mask bit is 0. Bits whose mask bit is 1 are ignored.
- R2: The type register holds the initiator selector in bits [1:0], the access-kind selector in bits [3:2] and the direction selector in bits [5:4]. In each selector, 01 accepts only the first option (processor, fetch, read; attribute input 0), 10 accepts only the second option (peripheral, data, write; attribute input 1), and 11 accepts either option.
- R3: If any selector is 00, no bus cycle sets the pending flag, even when every other field fits.
- R4: Only a cycle with bus_valid high is compared. A fitting cycle sets the pending flag at the next rising clock edge. Bus fields presented while bus_valid is low have no effect.
- R5: brk_req is high only while the flag is pending and imask is below 15. While imask is 15 the flag is kept, and brk_req rises in the same cycle that imask falls to 14 or lower.
- R6: A brk_ack sampled while brk_req is high clears the flag at that edge. A fitting cycle at the same edge keeps the flag set.
- R7: After reset, all three condition registers read 0 and brk_req is low.
- R8: Each register is written from cfg_wdata only when its own write enable is high. Its readback output shows the new value one cycle after the write, and the other registers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we_addr | input | 1 | Write enable for the break address register |
| cfg_we_mask | input | 1 | Write enable for the address mask register |
| cfg_we_type | input | 1 | Write enable for the cycle-type register |
| cfg_wdata | input | 32 | Write data shared by the three registers |
| cfg_addr_q | output | 32 | Break address readback |
| cfg_mask_q | output | 32 | Address mask readback |
| cfg_type_q | output | 6 | Cycle-type readback |
| bus_valid | input | 1 | Bus cycle strobe |
| bus_addr | input | 32 | Bus cycle address |
| bus_periph | input | 1 | 1 when a peripheral initiated the cycle, 0 when the processor did |
| bus_data | input | 1 | 1 for a data access, 0 for an instruction fetch |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| imask | input | 4 | Current interrupt mask level of the processor |
| brk_req | output | 1 | Break interrupt request |
| brk_ack | input | 1 | Acceptance acknowledge |

## Verification
A table of vectors runs the compare with exact addresses, with addresses that differ only in masked low or high bits, and with addresses that differ in one unmasked bit. This separates a correct mask polarity from an inverted or ignored mask. The same table pairs each selector code with attributes of both polarities, which separates the 01, 10 and 11 encodings and shows that a 00 in any single group suppresses a match. Directed cases hold imask at 15 and then lower it, drop the strobe while the fields still fit, and assert the acknowledge together with a new match. These cases show apart a request that is dropped, one that is delayed, and one that is wrongly cleared.

// File: rtl/brk_pkg.sv
package brk_pkg;
   localparam int unsigned NGRP  = 3;
   localparam int unsigned GRP_W = 2;
   localparam int unsigned TYP_W = NGRP * GRP_W;

   typedef enum logic [GRP_W-1:0] {
      SEL_OFF    = 2'b00,
      SEL_FIRST  = 2'b01,
      SEL_SECOND = 2'b10,
      SEL_ANY    = 2'b11
   } sel_e;

   // attribute bit order: 0 initiator, 1 access kind, 2 direction
   typedef logic [NGRP-1:0] attr_t;
endpackage

// File: rtl/brk_regs.sv
module brk_regs #(
   parameter int unsigned AW = 32,
   parameter int unsigned TW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_addr,
   input  logic          we_mask,
   input  logic          we_type,
   input  logic [AW-1:0] wdata,
   output logic [AW-1:0] addr_q,
   output logic [AW-1:0] mask_q,
   output logic [TW-1:0] type_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         mask_q <= '0;
         type_q <= '0;
      end else begin
         if (we_addr) addr_q <= wdata;
         if (we_mask) mask_q <= wdata;
         if (we_type) type_q <= wdata[TW-1:0];
      end
   end
endmodule

// File: rtl/brk_match.sv
module brk_match
   import brk_pkg::*;
#(
   parameter int unsigned AW = 32
) (
   input  logic             bus_valid,
   input  logic [AW-1:0]    bus_addr,
   input  attr_t            attr,
   input  logic [AW-1:0]    addr_q,
   input  logic [AW-1:0]    mask_q,
   input  logic [TYP_W-1:0] type_q,
   output logic             hit
);
   logic [NGRP-1:0] grp_ok;
   logic            addr_ok;

   assign addr_ok = (((addr_q ^ bus_addr) & ~mask_q) == '0);

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      sel_e sel;
      assign sel       = sel_e'(type_q[g*GRP_W +: GRP_W]);
      // a zero selector accepts neither option
      assign grp_ok[g] = (sel[0] & ~attr[g]) | (sel[1] & attr[g]);
   end

   assign hit = bus_valid & addr_ok & (&grp_ok);
endmodule

// File: rtl/brk_pend.sv
module brk_pend #(
   parameter int unsigned LW   = 4,
   parameter int unsigned PRIO = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hit,
   input  logic [LW-1:0] imask,
   input  logic          ack,
   output logic          pend_q,
   output logic          req
);
   assign req = pend_q & (imask < LW'(PRIO));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= (pend_q & ~(ack & req)) | hit;
   end
endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
   import brk_pkg::*;
#(
   parameter int unsigned AW   = 32,
   parameter int unsigned LW   = 4,
   parameter int unsigned PRIO = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we_addr,
   input  logic             cfg_we_mask,
   input  logic             cfg_we_type,
   input  logic [AW-1:0]    cfg_wdata,
   output logic [AW-1:0]    cfg_addr_q,
   output logic [AW-1:0]    cfg_mask_q,
   output logic [TYP_W-1:0] cfg_type_q,
   input  logic             bus_valid,
   input  logic [AW-1:0]    bus_addr,
   input  logic             bus_periph,
   input  logic             bus_data,
   input  logic             bus_write,
   input  logic [LW-1:0]    imask,
   output logic             brk_req,
   input  logic             brk_ack
);
   if (AW < TYP_W) begin : g_bad_aw
      $error("bus_break_unit: AW must hold the type field");
   end
   if (PRIO < 1 || PRIO >= (1 << LW)) begin : g_bad_prio
      $error("bus_break_unit: PRIO out of range for LW");
   end

   logic  hit;
   logic  pend_q;
   attr_t attr;

   assign attr = {bus_write, bus_data, bus_periph};

   brk_regs #(.AW(AW), .TW(TYP_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .we_addr(cfg_we_addr), .we_mask(cfg_we_mask), .we_type(cfg_we_type),
      .wdata(cfg_wdata),
      .addr_q(cfg_addr_q), .mask_q(cfg_mask_q), .type_q(cfg_type_q)
   );

   brk_match #(.AW(AW)) u_match (
      .bus_valid(bus_valid), .bus_addr(bus_addr), .attr(attr),
      .addr_q(cfg_addr_q), .mask_q(cfg_mask_q), .type_q(cfg_type_q),
      .hit(hit)
   );

   brk_pend #(.LW(LW), .PRIO(PRIO)) u_pend (
      .clk(clk), .rst_n(rst_n), .hit(hit), .imask(imask), .ack(brk_ack),
      .pend_q(pend_q), .req(brk_req)
   );
endmodule

// File: rtl/brk_checker.sv
module brk_checker
   import brk_pkg::*;
#(
   parameter int unsigned LW = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_valid,
   input logic [TYP_W-1:0] cfg_type_q,
   input logic [LW-1:0]    imask,
   input logic             pend_q,
   input logic             brk_req,
   input logic             brk_ack
);
   logic grp_zero;
   assign grp_zero = (cfg_type_q[1:0] == 2'b00) || (cfg_type_q[3:2] == 2'b00)
                  || (cfg_type_q[5:4] == 2'b00);

   p_no_req_when_zero_grp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      grp_zero && !pend_q |=> !pend_q);

   p_no_set_without_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid && !pend_q |=> !pend_q);

   p_blocked_at_top_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (imask == {LW{1'b1}}) |-> !brk_req);

   p_pending_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q && !brk_ack |=> pend_q);

   p_req_held_until_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req && !brk_ack && (imask != {LW{1'b1}}) |=> pend_q);

   p_reset_state_r7: assert property (@(posedge clk)
      $rose(rst_n) |-> (cfg_type_q == '0) && !brk_req);
endmodule

bind bus_break_unit brk_checker #(.LW(LW)) u_brk_checker (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .cfg_type_q(cfg_type_q),
   .imask(imask), .pend_q(pend_q), .brk_req(brk_req), .brk_ack(brk_ack)
);

// File: tb/test_bus_break_unit.sv
`timescale 1ns/1ps
module test_bus_break_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we_addr = 0, cfg_we_mask = 0, cfg_we_type = 0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_addr_q, cfg_mask_q;
   logic [5:0]  cfg_type_q;
   logic        bus_valid = 0;
   logic [31:0] bus_addr = '0;
   logic        bus_periph = 0, bus_data = 0, bus_write = 0;
   logic [3:0]  imask = '0;
   logic        brk_req;
   logic        brk_ack = 0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   bus_break_unit i_bus_break_unit (.*);

   typedef struct packed {
      logic [5:0]  typ;
      logic [31:0] ba;
      logic [31:0] bm;
      logic [31:0] a;
      logic        p, d, w, exp;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{6'b010101, 32'h0000_1000, 32'h0,          32'h0000_1000, 1'b0, 1'b0, 1'b0, 1'b1}, // R1 exact
      '{6'b010101, 32'h0000_1000, 32'h0,          32'h0000_1004, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 unmasked bit differs
      '{6'b010101, 32'h0000_1000, 32'h0000_000F,  32'h0000_100C, 1'b0, 1'b0, 1'b0, 1'b1}, // R1 masked low bits
      '{6'b010101, 32'h8000_0000, 32'h8000_0000,  32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b1}, // R1 masked top bit
      '{6'b010101, 32'h0000_1000, 32'h0,          32'h0000_1000, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 read-only vs write
      '{6'b111111, 32'h0000_2000, 32'h0,          32'h0000_2000, 1'b1, 1'b1, 1'b1, 1'b1}, // R2 any
      '{6'b101010, 32'h0000_2000, 32'h0,          32'h0000_2000, 1'b0, 1'b1, 1'b1, 1'b0}, // R2 second only, cpu
      '{6'b101010, 32'h0000_2000, 32'h0,          32'h0000_2000, 1'b1, 1'b1, 1'b1, 1'b1}, // R2 second only
      '{6'b011010, 32'h0000_3000, 32'h0,          32'h0000_3000, 1'b1, 1'b1, 1'b0, 1'b1}, // R2 mixed
      '{6'b001111, 32'h0000_3000, 32'h0,          32'h0000_3000, 1'b1, 1'b1, 1'b1, 1'b0}, // R3 direction 00
      '{6'b110011, 32'h0000_3000, 32'h0,          32'h0000_3000, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 kind 00
      '{6'b111111, 32'h1234_5678, 32'hFFFF_FFFF,  32'hCAFE_0000, 1'b0, 1'b1, 1'b0, 1'b1}  // R1 full mask
   };

   task automatic check(input bit cond, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!cond) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input int sel, input logic [31:0] d);
      cfg_wdata   = d;
      cfg_we_addr = (sel == 0);
      cfg_we_mask = (sel == 1);
      cfg_we_type = (sel == 2);
      tick();
      cfg_we_addr = 0; cfg_we_mask = 0; cfg_we_type = 0;
   endtask

   task automatic cycle(input logic [31:0] a, input logic p, input logic d, input logic w);
      bus_valid = 1; bus_addr = a; bus_periph = p; bus_data = d; bus_write = w;
      tick();
      bus_valid = 0;
   endtask

   task automatic acknowledge();
      brk_ack = 1;
      tick();
      brk_ack = 0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #12 rst_n = 1'b1;
      tick();
      // R7 reset state
      check(cfg_addr_q == 0 && cfg_mask_q == 0, "R7 addr/mask", cfg_addr_q | cfg_mask_q, 0);
      check(cfg_type_q == 0, "R7 type", 32'(cfg_type_q), 0);
      check(brk_req == 0, "R7 req", 32'(brk_req), 0);
      // R3 unprogrammed: address 0 with zero mask would fit, selectors are 00
      cycle(32'h0, 0, 0, 0);
      check(brk_req == 0, "R3 unprogrammed", 32'(brk_req), 0);

      // R8 per-register write enables and readback
      wr(0, 32'hA5A5_0001);
      check(cfg_addr_q == 32'hA5A5_0001, "R8 addr write", cfg_addr_q, 32'hA5A5_0001);
      check(cfg_mask_q == 0 && cfg_type_q == 0, "R8 others unchanged",
            cfg_mask_q | 32'(cfg_type_q), 0);
      wr(2, 32'hFFFF_FF2A);
      check(cfg_type_q == 6'h2A && cfg_addr_q == 32'hA5A5_0001, "R8 type write",
            32'(cfg_type_q), 32'h2A);

      // vector table: R1, R2, R3
      for (int i = 0; i < NV; i++) begin
         wr(0, VECS[i].ba);
         wr(1, VECS[i].bm);
         wr(2, 32'(VECS[i].typ));
         cycle(VECS[i].a, VECS[i].p, VECS[i].d, VECS[i].w);
         check(brk_req == VECS[i].exp, $sformatf("R1/R2/R3 vector %0d", i),
               32'(brk_req), 32'(VECS[i].exp));
         if (brk_req) begin
            acknowledge();
            check(brk_req == 0, "R6 ack clears", 32'(brk_req), 0);
         end
      end

      // R4 fields fit but strobe low
      wr(0, 32'h0000_4000); wr(1, 32'h0); wr(2, 32'h3F);
      bus_addr = 32'h0000_4000; bus_periph = 0; bus_data = 0; bus_write = 0;
      tick(); tick();
      check(brk_req == 0, "R4 no strobe", 32'(brk_req), 0);

      // R5 held at level 15, delivered at 14
      imask = 4'hF;
      cycle(32'h0000_4000, 0, 0, 0);
      check(brk_req == 0, "R5 blocked", 32'(brk_req), 0);
      tick(); tick(); tick();
      check(brk_req == 0, "R5 still blocked", 32'(brk_req), 0);
      imask = 4'hE;
      #1;
      check(brk_req == 1, "R5 delivered at 14", 32'(brk_req), 1);
      // ack while blocked has no effect
      imask = 4'hF;
      acknowledge();
      imask = 4'h3;
      #1;
      check(brk_req == 1, "R5 kept through masked ack", 32'(brk_req), 1);

      // R6 ack with simultaneous match keeps pending
      brk_ack = 1;
      cycle(32'h0000_4000, 1, 1, 1);
      brk_ack = 0;
      check(brk_req == 1, "R6 ack plus match", 32'(brk_req), 1);
      acknowledge();
      check(brk_req == 0, "R6 ack alone", 32'(brk_req), 0);

      // R7 reset clears programmed state
      rst_n = 0;
      #1;
      check(cfg_type_q == 0 && brk_req == 0, "R7 async reset", 32'(cfg_type_q), 0);
      tick();
      rst_n = 1;
      tick();

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule